// File: doc/BRIEF.md
# Windowed watchdog timer

This block is a watchdog that counts toward a programmable timeout. If software does not service it in time, it raises a system reset request. To service it, software makes two service-register writes in a row: `0x55` first, then `0xAA`. That sequence restarts the current period from zero. The count advances in one of two ways. It can advance once per pulse of a slow tick input, nominally 1 kHz and synchronous to the bus clock. Or it can advance on every bus-clock cycle.

A configuration port sets three things: the timeout length, the count source and a window mode. The port takes one write after reset and ignores every later write. In window mode the watchdog accepts service only in the last quarter of each period. Any service write before that point counts as a fault and raises the reset request. Window mode has effect only when the bus clock is the count source.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the request output is low, the period length select is `11`, the source select is 0 and window mode is off. With these defaults the first request follows 1024 tick pulses.
- R2: With period length select `00` the watchdog is off. No request is raised, whatever the ticks or service writes.
- R3: With source select 0, the count advances only on clock cycles where the tick input is high. Length selects `01`, `10` and `11` give periods of 32, 256 and 1024 ticks.
- R4: With source select 1, the count advances on every clock cycle. Length selects `01`, `10` and `11` give periods of 8192, 65536 and 262144 cycles. The request is visible in the cycle after the last counted edge of the period.
- R5: Each request lasts one cycle and the count restarts from zero with it. An unserviced watchdog therefore requests once per period.
- R6: A service write of `0x55` followed by a service write of `0xAA` restarts the period from zero, with no request. Cycles without service writes may separate the two writes.
- R7: After `0x55`, a service write of any other value abandons the sequence. A later `0xAA` then does not restart the period.
- R8: Window mode is on when the window bit is 1, the source select is 1 and the length select is non-zero. In that mode, any service write while the count is below three quarters of the period raises the request in the next cycle and restarts the period. The thresholds are 6144, 49152 and 196608.
- R9: In window mode, service writes made at or after the three-quarter count are accepted. The `0x55`/`0xAA` sequence then restarts the period normally.
- R10: With source select 0 the window bit has no effect. Early service writes raise no request.
- R11: The first configuration write after reset loads all three fields and restarts the count. Later configuration writes are ignored until the next reset.
- R12: A service write of `0xAA` that does not directly follow `0x55` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Slow tick, one bus-clock cycle high per tick |
| cfg_we_i | input | 1 | Configuration write strobe, accepted once after reset |
| cfg_tsel_i | input | 2 | Period length select, `00` turns the watchdog off |
| cfg_csel_i | input | 1 | Count source: 0 tick input, 1 bus clock |
| cfg_win_i | input | 1 | Window mode enable |
| svc_we_i | input | 1 | Service-register write strobe |
| svc_data_i | input | 8 | Service-register write data |
| rst_req_o | output | 1 | Reset request, one cycle per event |

## Verification
A reference model runs alongside the design and is compared with it on every cycle. Three kinds of stimulus are applied to it.
- Directed runs with no service writes check the exact cycle of each timeout for both count sources. This separates an off-by-one in the period from a correct count.
- Key sequences that are clean, broken by a stray byte, or start with `0xAA` alone separate a real restart from one that only looks like it.
- In window mode, writes placed one count before and exactly at the three-quarter point check the fault boundary. Random configurations with sparse, randomly mixed service bytes and late configuration writes then cover the remaining combinations.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  typedef struct packed {
    logic [1:0] tsel;
    logic       csel;
    logic       win;
  } wdt_cfg_t;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [1:0] TSEL_OFF   = 2'b00;
  localparam logic [1:0] TSEL_RST   = 2'b11;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
`timescale 1ns/1ps
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/wdt_cfg_lock.sv
`timescale 1ns/1ps
module wdt_cfg_lock
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we_i,
  input  wdt_cfg_t cfg_wdata_i,
  output wdt_cfg_t cfg_o,
  output logic     load_o
);

  logic     lock_q, lock_d;
  wdt_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  assign load_o = cfg_we_i && !lock_q;
  assign cfg_en = load_o;

  always_comb begin
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (load_o) begin
      cfg_d  = cfg_wdata_i;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{tsel: TSEL_RST, csel: 1'b0, win: 1'b0};
      lock_q <= 1'b0;
    end else if (cfg_en) begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign cfg_o = cfg_q;

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q));

  // R11
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

endmodule

// File: rtl/wdt_key_seq.sv
`timescale 1ns/1ps
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       flush_i,
  input  logic       svc_we_i,
  input  logic [7:0] svc_data_i,
  output logic       clr_o
);

  logic armed_q, armed_d;
  logic armed_en;

  assign clr_o = en_i && svc_we_i && armed_q && (svc_data_i == KEY_SECOND);

  always_comb begin
    armed_en = flush_i || (en_i && svc_we_i);
    armed_d  = armed_q;
    if (flush_i)                armed_d = 1'b0;
    else if (en_i && svc_we_i)  armed_d = (svc_data_i == KEY_FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  // R6
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(svc_we_i && (svc_data_i == KEY_FIRST)));

  // R7
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && en_i && svc_we_i && !flush_i && (svc_data_i != KEY_FIRST)) |=> !armed_q);

endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
  import wdt_pkg::*;
#(
  parameter int TICK_EXP1 = 5,
  parameter int TICK_EXP2 = 8,
  parameter int TICK_EXP3 = 10,
  parameter int BUS_EXP1  = 13,
  parameter int BUS_EXP2  = 16,
  parameter int BUS_EXP3  = 18,
  parameter int CNT_W     = 18
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  wdt_cfg_t cfg_i,
  input  logic     cfg_load_i,
  input  logic     svc_we_i,
  input  logic     key_clr_i,
  output logic     early_o,
  output logic     rst_req_o
);

  localparam int TEXP [4] = '{0, TICK_EXP1, TICK_EXP2, TICK_EXP3};
  localparam int BEXP [4] = '{0, BUS_EXP1, BUS_EXP2, BUS_EXP3};

  logic [CNT_W-1:0] tick_lm1 [4];
  logic [CNT_W-1:0] bus_lm1  [4];
  logic [CNT_W-1:0] bus_open [4];

  for (genvar g = 0; g < 4; g++) begin : g_lim
    if (g == 0) begin : g_off
      assign tick_lm1[g] = '0;
      assign bus_lm1[g]  = '0;
      assign bus_open[g] = '0;
    end else begin : g_on
      assign tick_lm1[g] = CNT_W'((64'd1 << TEXP[g]) - 64'd1);
      assign bus_lm1[g]  = CNT_W'((64'd1 << BEXP[g]) - 64'd1);
      assign bus_open[g] = CNT_W'((64'd1 << BEXP[g]) - (64'd1 << (BEXP[g] - 2)));
    end
  end

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             cnt_en;
  logic [CNT_W-1:0] lm1_sel, open_sel;
  logic             active, win_act, step, term;

  always_comb begin
    lm1_sel  = cfg_i.csel ? bus_lm1[cfg_i.tsel] : tick_lm1[cfg_i.tsel];
    open_sel = bus_open[cfg_i.tsel];
    active   = (cfg_i.tsel != TSEL_OFF);
    win_act  = active && cfg_i.csel && cfg_i.win;
    early_o  = win_act && svc_we_i && (cnt_q < open_sel);
    step     = active && (cfg_i.csel || tick_i);
    term     = step && (cnt_q == lm1_sel);
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    req_d  = 1'b0;
    if (cfg_load_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (early_o) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      req_d  = 1'b1;
    end else if (key_clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (term) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      req_d  = 1'b1;
    end else if (step) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign rst_req_o = req_q;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lm1_sel);

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (cnt_q == '0));

  // R8
  early_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early_o && !cfg_load_i) |=> (rst_req_o && (cnt_q == '0)));

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.tsel == TSEL_OFF) |=> !rst_req_o);

  // R6
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_clr_i && !early_o && !cfg_load_i) |=> ((cnt_q == '0) && !rst_req_o));

endmodule

// File: rtl/windowed_watchdog.sv
`timescale 1ns/1ps
module windowed_watchdog
  import wdt_pkg::*;
#(
  parameter int TICK_EXP1 = 5,
  parameter int TICK_EXP2 = 8,
  parameter int TICK_EXP3 = 10,
  parameter int BUS_EXP1  = 13,
  parameter int BUS_EXP2  = 16,
  parameter int BUS_EXP3  = 18,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_tsel_i,
  input  logic       cfg_csel_i,
  input  logic       cfg_win_i,
  input  logic       svc_we_i,
  input  logic [7:0] svc_data_i,
  output logic       rst_req_o
);

  localparam int CNT_W = max_of(max_of(max_of(TICK_EXP1, TICK_EXP2), max_of(TICK_EXP3, BUS_EXP1)),
                                max_of(BUS_EXP2, BUS_EXP3));

  logic     rst_sync_n;
  wdt_cfg_t cfg_wdata, cfg;
  logic     cfg_load;
  logic     key_clr, early, key_en, key_flush;

  assign cfg_wdata = '{tsel: cfg_tsel_i, csel: cfg_csel_i, win: cfg_win_i};
  assign key_en    = (cfg.tsel != TSEL_OFF);
  assign key_flush = early || cfg_load;

  wdt_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdt_cfg_lock u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata),
    .cfg_o       (cfg),
    .load_o      (cfg_load)
  );

  wdt_key_seq u_key (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (key_en),
    .flush_i    (key_flush),
    .svc_we_i   (svc_we_i),
    .svc_data_i (svc_data_i),
    .clr_o      (key_clr)
  );

  wdt_core #(
    .TICK_EXP1 (TICK_EXP1), .TICK_EXP2 (TICK_EXP2), .TICK_EXP3 (TICK_EXP3),
    .BUS_EXP1  (BUS_EXP1),  .BUS_EXP2  (BUS_EXP2),  .BUS_EXP3  (BUS_EXP3),
    .CNT_W     (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .cfg_i      (cfg),
    .cfg_load_i (cfg_load),
    .svc_we_i   (svc_we_i),
    .key_clr_i  (key_clr),
    .early_o    (early),
    .rst_req_o  (rst_req_o)
  );

endmodule

// File: tb/sim_windowed_watchdog.sv
`timescale 1ns/1ps
module sim_windowed_watchdog;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       cfg_we;
  logic [1:0] cfg_tsel;
  logic       cfg_csel, cfg_win;
  logic       svc_we;
  logic [7:0] svc_data;
  logic       rst_req;

  always #2.5 clk = ~clk;

  windowed_watchdog u0 (
    .clk (clk), .rst_n (rst_n), .tick_i (tick),
    .cfg_we_i (cfg_we), .cfg_tsel_i (cfg_tsel), .cfg_csel_i (cfg_csel), .cfg_win_i (cfg_win),
    .svc_we_i (svc_we), .svc_data_i (svc_data), .rst_req_o (rst_req)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    pulses  = 0;
  int    tgap    = 0;
  int    tph     = 0;
  string phase   = "R1";

  // reference model, built from the requirements
  logic [1:0] m_tsel;
  logic       m_csel, m_win, m_lock, m_arm, m_req;
  int         m_cnt;

  function automatic int period_of(input logic [1:0] ts, input logic cs);
    int e;
    case (ts)
      2'd1:    e = cs ? 13 : 5;
      2'd2:    e = cs ? 16 : 8;
      2'd3:    e = cs ? 18 : 10;
      default: e = 0;
    endcase
    return (ts == 2'd0) ? 0 : (1 << e);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tsel <= 2'b11; m_csel <= 1'b0; m_win <= 1'b0; m_lock <= 1'b0;
      m_arm  <= 1'b0;  m_req  <= 1'b0; m_cnt <= 0;
    end else if (cfg_we && !m_lock) begin
      m_tsel <= cfg_tsel; m_csel <= cfg_csel; m_win <= cfg_win; m_lock <= 1'b1;
      m_cnt  <= 0; m_arm <= 1'b0; m_req <= 1'b0;
    end else begin : mstep
      int   per;
      logic on, fault, clear, adv;
      per   = period_of(m_tsel, m_csel);
      on    = (m_tsel != 2'd0);
      fault = on && m_win && m_csel && svc_we && (m_cnt < per - per / 4);
      clear = on && svc_we && (svc_data == 8'hAA) && m_arm;
      adv   = on && (m_csel || tick);
      if (fault) begin
        m_cnt <= 0; m_req <= 1'b1; m_arm <= 1'b0;
      end else begin
        if (on && svc_we) m_arm <= (svc_data == 8'h55);
        if (clear) begin
          m_cnt <= 0; m_req <= 1'b0;
        end else if (adv && (m_cnt == per - 1)) begin
          m_cnt <= 0; m_req <= 1'b1;
        end else begin
          if (adv) m_cnt <= m_cnt + 1;
          m_req <= 1'b0;
        end
      end
    end
  end

  task automatic chk(input logic exp, input string tag);
    n_tests++;
    if (rst_req !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_req_o actual=%0b expected=%0b at %0t", tag, rst_req, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: request pulses actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic cw,
                      input logic [1:0] ts, input logic cs, input logic wn);
    @(negedge clk);
    chk(m_req, phase);
    if (rst_req === 1'b1) pulses++;
    if (tgap > 0) begin
      tick = (tph == 0);
      tph  = (tph + 1) % tgap;
    end else begin
      tick = 1'b0;
    end
    svc_we = we; svc_data = d; cfg_we = cw; cfg_tsel = ts; cfg_csel = cs; cfg_win = wn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic svc(input logic [7:0] d);
    step(1'b1, d, 1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic cfg(input logic [1:0] ts, input logic cs, input logic wn);
    step(1'b0, 8'h00, 1'b1, ts, cs, wn);
  endtask

  // idle step that also checks the result of the previous edge
  task automatic look(input logic exp, input string tag);
    @(negedge clk);
    chk(exp, tag);
    if (rst_req === 1'b1) pulses++;
    #0;
    step_drive_idle();
  endtask

  task automatic step_drive_idle();
    if (tgap > 0) begin
      tick = (tph == 0);
      tph  = (tph + 1) % tgap;
    end else begin
      tick = 1'b0;
    end
    svc_we = 1'b0; svc_data = 8'h00; cfg_we = 1'b0; cfg_tsel = 2'b00; cfg_csel = 1'b0; cfg_win = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tgap = 0; tph = 0;
    tick = 1'b0; svc_we = 1'b0; svc_data = 8'h00; cfg_we = 1'b0;
    cfg_tsel = 2'b00; cfg_csel = 1'b0; cfg_win = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  localparam int OPEN1 = 6144;

  initial begin
    void'($urandom(32'd20250117));
    rst_n = 1'b0;
    do_reset();

    // R1: reset state and default period of 1024 ticks
    phase = "R1";
    chk(1'b0, "R1");
    tgap = 1; pulses = 0;
    idle(1100);
    chk_int(pulses, 1, "R1");

    // R3: tick-source periods
    do_reset(); phase = "R3";
    tgap = 2; cfg(2'b01, 1'b0, 1'b0); pulses = 0;
    idle(200);
    chk_int(pulses, 3, "R3");
    do_reset();
    tgap = 1; cfg(2'b10, 1'b0, 1'b0); pulses = 0;
    idle(600);
    chk_int(pulses, 2, "R3");

    // R4, R5, R11: bus source 8192, exact edges, repeat, later config ignored
    do_reset(); phase = "R4";
    cfg(2'b01, 1'b1, 1'b0);
    cfg(2'b00, 1'b0, 1'b1);
    idle(8190);
    look(1'b0, "R4");
    look(1'b1, "R4");
    look(1'b0, "R5");
    idle(8190);
    look(1'b1, "R5");
    look(1'b0, "R11");

    // R4: 65536 cycles
    do_reset(); phase = "R4";
    cfg(2'b10, 1'b1, 1'b0); pulses = 0;
    idle(65540);
    chk_int(pulses, 1, "R4");

    // R2: disabled, service traffic ignored
    do_reset(); phase = "R2";
    tgap = 1; cfg(2'b00, 1'b1, 1'b1); pulses = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) svc(8'($urandom));
      else idle(1);
    end
    chk_int(pulses, 0, "R2");

    // R6, R7, R12: key sequences, bus source, no window
    do_reset(); phase = "R6";
    cfg(2'b01, 1'b1, 1'b0);
    idle(5000);
    svc(8'h55); svc(8'hAA);
    pulses = 0; idle(5000);
    chk_int(pulses, 0, "R6");
    phase = "R7";
    svc(8'h55); svc(8'h12); svc(8'hAA);
    pulses = 0; idle(4000);
    chk_int(pulses, 1, "R7");
    phase = "R12";
    pulses = 0; svc(8'hAA); idle(8000);
    chk_int(pulses, 1, "R12");

    // R10: window bit with tick source
    do_reset(); phase = "R10";
    tgap = 2; cfg(2'b01, 1'b0, 1'b1); pulses = 0;
    for (int i = 0; i < 40; i++) svc(8'h00);
    chk_int(pulses, 0, "R10");

    // R8, R9: window boundaries
    do_reset(); phase = "R8";
    cfg(2'b01, 1'b1, 1'b1);
    idle(OPEN1 - 1);
    svc(8'h00);
    look(1'b1, "R8");
    look(1'b0, "R5");
    phase = "R9";
    idle(OPEN1 - 2);
    svc(8'h55); svc(8'hAA);
    idle(8000);
    look(1'b0, "R9");
    idle(300);

    // random configurations and service traffic
    for (int r = 0; r < 6; r++) begin
      logic       cs, wn;
      logic [1:0] ts;
      do_reset(); phase = "R11";
      cs = 1'($urandom % 2);
      ts = cs ? 2'b01 : 2'($urandom % 4);
      wn = 1'($urandom % 2);
      tgap = 1 + int'($urandom % 3);
      cfg(ts, cs, wn);
      for (int i = 0; i < 2500; i++) begin
        int k;
        k = int'($urandom % 32);
        if (k == 0)      svc(8'h55);
        else if (k == 1) svc(8'hAA);
        else if (k == 2) svc(8'($urandom));
        else if (k == 3) cfg(2'($urandom), 1'($urandom), 1'($urandom));
        else             idle(1);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog in phase %s: actual=still running expected=finished", phase);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule